// File: doc/BRIEF.md
# Segment Table Address Translator

This block turns a logical address, given as a segment number paired with an offset into that segment, into a physical address. For each request it reads the segment's descriptor from a table held in ordinary memory. A descriptor carries the segment's starting physical address and its length in bytes. The block then checks that the offset falls inside the segment. If it does, the block adds the offset to the starting address and returns the result.

Two configuration registers place the table. One holds the byte address of the first descriptor. The other holds the number of descriptors, so any segment number at or beyond that count is refused before memory is touched. The block handles a single translation at a time. It signals completion with a one-cycle done pulse carrying the physical address, or with a one-cycle fault pulse carrying a fault code. A processor pipeline or DMA front end uses it to relocate and protect accesses made on behalf of one address space.

Top module: `seg_xlate`

## Requirements
- R1: After reset, `req_ready` is high, `done`, `fault` and `mem_rd_valid` are low, and both configuration registers read as zero, so the first request faults with code 1.
- R2: A request whose segment number is greater than or equal to the table-length register faults with `fault_code` 1 in the cycle after acceptance and issues no memory read.
- R3: For an in-range segment, the block issues two reads in order. The first is at table base + segment × 8 and returns the segment base. The second is at that address + 4 and returns the segment limit.
- R4: When the offset is strictly below the limit, `done` pulses with `phys_addr` equal to segment base + offset.
- R5: When the offset is equal to or above the limit, `fault` pulses with `fault_code` 2 and `done` stays low.
- R6: `req_ready` goes low in the cycle after a request is accepted and stays low until the cycle after the done or fault pulse. `req_valid` has no effect while it is low.
- R7: `done` and `fault` each last exactly one cycle and are never high together. `fault_code` is 0 whenever `fault` is low.
- R8: While `mem_rd_valid` is high and `mem_rd_ready` is low, the read request and its address hold steady.
- R9: A configuration write with `cfg_sel` 0 loads the table base and one with `cfg_sel` 1 loads the table length. The request's write flag is returned on `done_write` with `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_sel | input | 1 | 0 selects table base, 1 selects table length |
| cfg_wdata | input | AW | Configuration write data |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_seg | input | SEG_W | Segment number |
| req_off | input | AW | Offset within the segment |
| req_write | input | 1 | Access kind of the request (1 = write) |
| mem_rd_valid | output | 1 | Descriptor read request |
| mem_rd_ready | input | 1 | Memory accepts the read request |
| mem_rd_addr | output | AW | Descriptor word byte address |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | AW | Read data |
| done | output | 1 | Translation succeeded (one-cycle pulse) |
| phys_addr | output | AW | Physical address, valid with done |
| done_write | output | 1 | Access kind of the completed request |
| fault | output | 1 | Translation refused (one-cycle pulse) |
| fault_code | output | 2 | 1 = segment out of range, 2 = offset past limit |

## Verification
The checker watches the handshake properties on every cycle. These are the single-cycle, mutually exclusive result pulses, a zero fault code outside a fault, the busy window of `req_ready`, and the held read request under memory back-pressure. Arithmetic results can only be shown by the bench scenarios, which compare against a modelled descriptor table. These include the descriptor addresses and their order, the physical address sum, and the exact boundary where the offset equals the limit. The same holds for the one-cycle latency of a range fault and for the absence of memory traffic on refused segments.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

   typedef enum logic [1:0] {
      FLT_NONE = 2'd0,
      FLT_SEG  = 2'd1,
      FLT_OFF  = 2'd2
   } flt_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_REQ_BASE,
      ST_WAIT_BASE,
      ST_REQ_LIM,
      ST_WAIT_LIM,
      ST_EVAL,
      ST_SEG_FLT
   } xl_state_e;

   localparam int unsigned CFG_SEL_BASE = 0;
   localparam int unsigned CFG_SEL_LEN  = 1;

endpackage

// File: rtl/seg_xlate_cfg.sv
module seg_xlate_cfg #(
   parameter int unsigned AW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_we,
   input  logic          cfg_sel,
   input  logic [AW-1:0] cfg_wdata,
   output logic [AW-1:0] tbl_base,
   output logic [AW-1:0] tbl_len
);
   import seg_xlate_pkg::*;

   logic [AW-1:0] base_q;
   logic [AW-1:0] len_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         len_q  <= '0;
      end else if (cfg_we) begin
         if (cfg_sel == 1'(CFG_SEL_LEN)) begin
            len_q <= cfg_wdata;
         end else begin
            base_q <= cfg_wdata;
         end
      end
   end

   assign tbl_base = base_q;
   assign tbl_len  = len_q;
endmodule

// File: rtl/seg_xlate_addr.sv
module seg_xlate_addr #(
   parameter int unsigned AW          = 32,
   parameter int unsigned SEG_W       = 8,
   parameter int unsigned ENTRY_BYTES = 8
) (
   input  logic [AW-1:0]    tbl_base,
   input  logic [SEG_W-1:0] seg,
   input  logic             word_sel,
   output logic [AW-1:0]    rd_addr
);
   localparam int unsigned WORD_BYTES = AW / 8;
   localparam bit          ENTRY_POW2 = ((ENTRY_BYTES & (ENTRY_BYTES - 1)) == 0);
   localparam int unsigned ENTRY_SHIFT = $clog2(ENTRY_BYTES);

   logic [AW-1:0] entry_off;
   logic [AW-1:0] word_off;

   generate
      if (ENTRY_POW2) begin : g_shift
         assign entry_off = AW'(seg) << ENTRY_SHIFT;
      end else begin : g_mult
         assign entry_off = AW'(seg) * AW'(ENTRY_BYTES);
      end
   endgenerate

   assign word_off = word_sel ? AW'(WORD_BYTES) : '0;
   assign rd_addr  = tbl_base + entry_off + word_off;
endmodule

// File: rtl/seg_xlate_bound.sv
module seg_xlate_bound #(
   parameter int unsigned AW = 32
) (
   input  logic [AW-1:0] seg_base,
   input  logic [AW-1:0] seg_limit,
   input  logic [AW-1:0] offset,
   output logic          in_bounds,
   output logic [AW-1:0] phys
);
   assign in_bounds = (offset < seg_limit);
   assign phys      = seg_base + offset;
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate #(
   parameter int unsigned AW          = 32,
   parameter int unsigned SEG_W       = 8,
   parameter int unsigned ENTRY_BYTES = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic             cfg_sel,
   input  logic [AW-1:0]    cfg_wdata,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [SEG_W-1:0] req_seg,
   input  logic [AW-1:0]    req_off,
   input  logic             req_write,
   output logic             mem_rd_valid,
   input  logic             mem_rd_ready,
   output logic [AW-1:0]    mem_rd_addr,
   input  logic             mem_rsp_valid,
   input  logic [AW-1:0]    mem_rsp_data,
   output logic             done,
   output logic [AW-1:0]    phys_addr,
   output logic             done_write,
   output logic             fault,
   output logic [1:0]       fault_code
);
   import seg_xlate_pkg::*;

   generate
      if (AW % 8 != 0) begin : g_bad_aw
         $error("seg_xlate: AW must be a whole number of bytes");
      end
      if (SEG_W == 0 || SEG_W >= AW) begin : g_bad_seg
         $error("seg_xlate: SEG_W must be between 1 and AW-1");
      end
      if (ENTRY_BYTES < 2 * (AW / 8)) begin : g_bad_entry
         $error("seg_xlate: an entry must hold a base word and a limit word");
      end
   endgenerate

   xl_state_e        state_q, state_d;
   logic [SEG_W-1:0] seg_q;
   logic [AW-1:0]    off_q;
   logic             wr_q;
   logic [AW-1:0]    sbase_q;
   logic [AW-1:0]    slim_q;
   logic [AW-1:0]    tbl_base;
   logic [AW-1:0]    tbl_len;
   logic             in_bounds;
   logic [AW-1:0]    phys;
   logic             accept;
   logic             seg_oob;

   seg_xlate_cfg #(.AW(AW)) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_we   (cfg_we),
      .cfg_sel  (cfg_sel),
      .cfg_wdata(cfg_wdata),
      .tbl_base (tbl_base),
      .tbl_len  (tbl_len)
   );

   seg_xlate_addr #(.AW(AW), .SEG_W(SEG_W), .ENTRY_BYTES(ENTRY_BYTES)) u_addr (
      .tbl_base(tbl_base),
      .seg     (seg_q),
      .word_sel(state_q == ST_REQ_LIM),
      .rd_addr (mem_rd_addr)
   );

   seg_xlate_bound #(.AW(AW)) u_bound (
      .seg_base (sbase_q),
      .seg_limit(slim_q),
      .offset   (off_q),
      .in_bounds(in_bounds),
      .phys     (phys)
   );

   assign req_ready = (state_q == ST_IDLE);
   assign accept    = req_valid && req_ready;
   assign seg_oob   = (AW'(req_seg) >= tbl_len);

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:      if (accept) state_d = seg_oob ? ST_SEG_FLT : ST_REQ_BASE;
         ST_REQ_BASE:  if (mem_rd_ready) state_d = ST_WAIT_BASE;
         ST_WAIT_BASE: if (mem_rsp_valid) state_d = ST_REQ_LIM;
         ST_REQ_LIM:   if (mem_rd_ready) state_d = ST_WAIT_LIM;
         ST_WAIT_LIM:  if (mem_rsp_valid) state_d = ST_EVAL;
         ST_EVAL:      state_d = ST_IDLE;
         ST_SEG_FLT:   state_d = ST_IDLE;
         default:      state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         seg_q   <= '0;
         off_q   <= '0;
         wr_q    <= 1'b0;
         sbase_q <= '0;
         slim_q  <= '0;
      end else begin
         state_q <= state_d;
         if (accept) begin
            seg_q <= req_seg;
            off_q <= req_off;
            wr_q  <= req_write;
         end
         if (state_q == ST_WAIT_BASE && mem_rsp_valid) sbase_q <= mem_rsp_data;
         if (state_q == ST_WAIT_LIM && mem_rsp_valid)  slim_q  <= mem_rsp_data;
      end
   end

   assign mem_rd_valid = (state_q == ST_REQ_BASE) || (state_q == ST_REQ_LIM);

   always_comb begin
      done       = 1'b0;
      fault      = 1'b0;
      fault_code = FLT_NONE;
      if (state_q == ST_EVAL) begin
         done  = in_bounds;
         fault = !in_bounds;
         if (!in_bounds) fault_code = FLT_OFF;
      end else if (state_q == ST_SEG_FLT) begin
         fault      = 1'b1;
         fault_code = FLT_SEG;
      end
   end

   assign phys_addr  = phys;
   assign done_write = wr_q;
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
   parameter int unsigned AW    = 32,
   parameter int unsigned SEG_W = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          req_valid,
   input logic          req_ready,
   input logic          mem_rd_valid,
   input logic          mem_rd_ready,
   input logic [AW-1:0] mem_rd_addr,
   input logic          done,
   input logic          fault,
   input logic [1:0]    fault_code
);
   p_pulse_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && fault));

   p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_fault_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      fault |=> !fault);

   p_code_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !fault |-> fault_code == 2'd0);

   p_code_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> fault_code != 2'd0);

   p_busy_after_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   p_ready_after_result_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (done || fault) |=> req_ready);

   p_no_read_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !mem_rd_valid);

   p_read_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));
endmodule

bind seg_xlate seg_xlate_chk #(.AW(AW), .SEG_W(SEG_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_valid   (req_valid),
   .req_ready   (req_ready),
   .mem_rd_valid(mem_rd_valid),
   .mem_rd_ready(mem_rd_ready),
   .mem_rd_addr (mem_rd_addr),
   .done        (done),
   .fault       (fault),
   .fault_code  (fault_code)
);

// File: tb/seg_xlate_bench.sv
module seg_xlate_bench;
   localparam int unsigned AW    = 32;
   localparam int unsigned SEG_W = 8;
   localparam logic [31:0] TBASE = 32'h0000_2000;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             cfg_we = 1'b0;
   logic             cfg_sel = 1'b0;
   logic [AW-1:0]    cfg_wdata = '0;
   logic             req_valid = 1'b0;
   logic             req_ready;
   logic [SEG_W-1:0] req_seg = '0;
   logic [AW-1:0]    req_off = '0;
   logic             req_write = 1'b0;
   logic             mem_rd_valid;
   logic             mem_rd_ready = 1'b1;
   logic [AW-1:0]    mem_rd_addr;
   logic             mem_rsp_valid = 1'b0;
   logic [AW-1:0]    mem_rsp_data = '0;
   logic             done;
   logic [AW-1:0]    phys_addr;
   logic             done_write;
   logic             fault;
   logic [1:0]       fault_code;

   int checks = 0;
   int failures = 0;
   int rd_cnt = 0;
   logic [31:0] rd_log [64];
   bit finished = 0;

   always #2 clk = ~clk;

   seg_xlate u_seg_xlate (.*);

   function automatic logic [31:0] desc_word(input logic [31:0] a);
      logic [31:0] e;
      e = (a - TBASE) >> 3;
      if (a[2] == 1'b0) return 32'h4000_0000 + (e << 16);
      return 32'h40 + e * 32'h10;
   endfunction

   always @(posedge clk) begin
      if (mem_rd_valid && mem_rd_ready) begin
         rd_log[rd_cnt[5:0]] <= mem_rd_addr;
         rd_cnt <= rd_cnt + 1;
         mem_rsp_valid <= 1'b1;
         mem_rsp_data  <= desc_word(mem_rd_addr);
      end else begin
         mem_rsp_valid <= 1'b0;
      end
   end

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic cfg_write(input logic sel, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   // Issues one request and waits for its result; records latency and busy behaviour.
   task automatic xlate(input logic [7:0] seg, input logic [31:0] off, input logic wr,
                        output bit got_done, output bit got_fault, output logic [1:0] code,
                        output logic [31:0] pa, output logic got_wr, output int cyc, output bit busy_ok);
      got_done = 0; got_fault = 0; code = 0; pa = 0; got_wr = 0; cyc = 0; busy_ok = 1;
      @(negedge clk);
      req_valid = 1'b1; req_seg = seg; req_off = off; req_write = wr;
      @(negedge clk);
      req_valid = 1'b1; req_seg = seg + 8'd1; req_off = 32'hFFFF; req_write = ~wr;
      for (int i = 1; i < 60; i++) begin
         cyc = i;
         if (done || fault) begin
            got_done = done; got_fault = fault; code = fault_code;
            pa = phys_addr; got_wr = done_write;
            req_valid = 1'b0;
            break;
         end
         if (req_ready) busy_ok = 0;
         @(negedge clk);
      end
      req_valid = 1'b0;
      @(negedge clk);
      if (done || fault || !req_ready) busy_ok = 0;
   endtask

   task automatic t_reset();
      bit d, f, b; logic [1:0] c; logic [31:0] p; logic w; int n, r0;
      check(req_ready == 1'b1, "R1 ready after reset", 32'(req_ready), 1);
      check(!done && !fault && !mem_rd_valid, "R1 outputs idle after reset",
            {29'b0, done, fault, mem_rd_valid}, 0);
      r0 = rd_cnt;
      xlate(8'd0, 32'd0, 1'b0, d, f, c, p, w, n, b);
      check(f && c == 2'd1, "R1 unprogrammed length faults code 1", 32'(c), 1);
      check(rd_cnt == r0, "R1 no read when unprogrammed", 32'(rd_cnt - r0), 0);
   endtask

   task automatic t_hit(input logic [7:0] seg, input logic [31:0] off, input logic wr);
      bit d, f, b; logic [1:0] c; logic [31:0] p, eb; logic w; int n, r0;
      r0 = rd_cnt;
      eb = 32'h4000_0000 + (32'(seg) << 16);
      xlate(seg, off, wr, d, f, c, p, w, n, b);
      check(d && !f, "R4 in-bounds request completes", {30'b0, d, f}, 32'h2);
      check(p == eb + off, "R4 physical address", p, eb + off);
      check(w == wr, "R9 write flag returned", 32'(w), 32'(wr));
      check(rd_cnt - r0 == 2, "R3 two descriptor reads", 32'(rd_cnt - r0), 2);
      check(rd_log[r0[5:0]] == TBASE + 32'(seg) * 8, "R3 base word address",
            rd_log[r0[5:0]], TBASE + 32'(seg) * 8);
      check(rd_log[(r0 + 1) & 63] == TBASE + 32'(seg) * 8 + 4, "R3 limit word address",
            rd_log[(r0 + 1) & 63], TBASE + 32'(seg) * 8 + 4);
      check(b, "R6 ready low while busy, ignored input, R7 single pulse", 32'(b), 1);
   endtask

   task automatic t_limit_edge();
      bit d, f, b; logic [1:0] c; logic [31:0] p; logic w; int n, r0;
      xlate(8'd1, 32'h4F, 1'b0, d, f, c, p, w, n, b);
      check(d && p == 32'h4001_004F, "R4 offset one below limit", p, 32'h4001_004F);
      r0 = rd_cnt;
      xlate(8'd1, 32'h50, 1'b1, d, f, c, p, w, n, b);
      check(f && c == 2'd2, "R5 offset equal to limit faults code 2", 32'(c), 2);
      check(!d, "R5 no done on limit fault", 32'(d), 0);
      check(rd_cnt - r0 == 2, "R5 descriptor still read", 32'(rd_cnt - r0), 2);
      xlate(8'd0, 32'hFFFF_0000, 1'b0, d, f, c, p, w, n, b);
      check(f && c == 2'd2 && b, "R5 large offset faults, R7 pulse", 32'(c), 2);
   endtask

   task automatic t_seg_range(input logic [7:0] seg);
      bit d, f, b; logic [1:0] c; logic [31:0] p; logic w; int n, r0;
      r0 = rd_cnt;
      xlate(seg, 32'd0, 1'b0, d, f, c, p, w, n, b);
      check(f && c == 2'd1, "R2 segment out of range code", 32'(c), 1);
      check(n == 1, "R2 fault one cycle after acceptance", 32'(n), 1);
      check(rd_cnt == r0, "R2 no memory read", 32'(rd_cnt - r0), 0);
   endtask

   task automatic t_stall();
      bit ok; logic [31:0] a0;
      ok = 1;
      mem_rd_ready = 1'b0;
      @(negedge clk);
      req_valid = 1'b1; req_seg = 8'd3; req_off = 32'h20; req_write = 1'b0;
      @(negedge clk);
      req_valid = 1'b0;
      a0 = mem_rd_addr;
      for (int i = 0; i < 3; i++) begin
         if (!mem_rd_valid || mem_rd_addr != a0) ok = 0;
         @(negedge clk);
      end
      check(ok && a0 == TBASE + 24, "R8 read held under back-pressure", a0, TBASE + 24);
      mem_rd_ready = 1'b1;
      ok = 0;
      for (int i = 0; i < 20; i++) begin
         if (done) begin
            ok = (phys_addr == 32'h4003_0020);
            break;
         end
         @(negedge clk);
      end
      check(ok, "R8 result correct after stall", phys_addr, 32'h4003_0020);
      @(negedge clk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         failures++;
         checks++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      cfg_write(1'b0, TBASE);   // R9 base select
      cfg_write(1'b1, 32'd4);   // R9 length select
      t_hit(8'd2, 32'h10, 1'b1);
      t_hit(8'd3, 32'h0, 1'b0);
      t_hit(8'd0, 32'h3F, 1'b1);
      t_limit_edge();
      t_seg_range(8'd4);
      t_seg_range(8'd200);
      t_stall();
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule